// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block accepts write-only configuration traffic on a three-wire serial link (an active-low select, a serial clock and a serial data line) and holds the result in a small register file. Its parallel outputs set up a converter front end. All three serial inputs are asynchronous to the block's system clock. Each one passes through a synchronizer chain, and rising edges of the serial clock are found by edge detection on the system clock.

Each transfer is a 12-bit frame: a 4-bit register address followed by an 8-bit data byte, both sent most significant bit first. Bits are shifted only while the select is low. The word is committed only when the select returns high, and only if at least 12 bits arrived. If more than 12 bits arrived, the last 12 are used. Frames with fewer bits are dropped, as are frames aimed at an address outside the four defined registers.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset every output is zero: clamp_code, gain_code, gain_off, out_en_n, clamp_sel, twos_out, clamp_dis and pwr_down.
- R2: A frame sends address bits 3..0 and then data bits 7..0, each MSB first. A committed write to address 0 sets clamp_code[7:0] to the data byte.
- R3: A committed write to address 1 sets clamp_code[9:8] from data bits 1:0.
- R4: A committed write to address 2 sets gain_code from data bits 2:0 and gain_off from data bit 3.
- R5: A committed write to address 3 sets pwr_down from bit 0, clamp_dis from bit 1, twos_out from bit 2, clamp_sel from bit 3 and out_en_n from bit 4.
- R6: Outputs change only after a rising edge of the select. A complete frame that is held with the select low leaves every output unchanged.
- R7: A frame with fewer than 12 serial clock rising edges before the select rises is discarded.
- R8: A frame with more than 12 bits commits the last 12 bits received.
- R9: Writes to addresses 4 to 15 change no output.
- R10: Serial clock edges while the select is high are ignored. The bit count restarts at zero on each falling edge of the select.
- R11: Data bits outside the defined fields of addresses 1, 2 and 3 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low; rising edge commits |
| sclk | input | 1 | Serial clock, data sampled on its rising edge |
| sdata | input | 1 | Serial data, MSB first |
| clamp_code | output | 10 | Clamp DAC code |
| gain_code | output | 3 | Gain setting |
| gain_off | output | 1 | Gain stage bypass flag |
| out_en_n | output | 1 | Output enable, active low |
| clamp_sel | output | 1 | Clamp mode select |
| twos_out | output | 1 | Two's-complement output format |
| clamp_dis | output | 1 | Clamp disable |
| pwr_down | output | 1 | Power down |

## Verification
The bench builds the block with three synchronizer stages rather than the default two. This lengthens the path from a pin to a commit. It also confirms that the serial timing used in the bench, about ten system clocks per bit, still allows clean edge detection. With the longer latency, the checks made while the select is held low after a full frame, and those made after select rises with too few or too many bits, all test the commit rule and the bit count rather than pin timing.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BITS   = 4,
  parameter int DATA_BITS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdata,
  output logic [9:0] clamp_code,
  output logic [2:0] gain_code,
  output logic       gain_off,
  output logic       out_en_n,
  output logic       clamp_sel,
  output logic       twos_out,
  output logic       clamp_dis,
  output logic       pwr_down
);
  localparam int FRAME_BITS = ADDR_BITS + DATA_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  logic [SYNC_STAGES-1:0] cs_sync, ck_sync, sd_sync;
  logic                   cs_q, ck_q;
  logic [FRAME_BITS-1:0]  shift;
  logic [CNT_W-1:0]       cnt;

  logic [7:0] dac_lo;
  logic [1:0] dac_hi;
  logic [3:0] gain_r;
  logic [4:0] ctl_r;

  wire cs_s = cs_sync[SYNC_STAGES-1];
  wire ck_s = ck_sync[SYNC_STAGES-1];
  wire sd_s = sd_sync[SYNC_STAGES-1];

  wire cs_rise = cs_s & ~cs_q;
  wire cs_fall = ~cs_s & cs_q;
  wire ck_rise = ck_s & ~ck_q;

  wire [ADDR_BITS-1:0] f_addr = shift[FRAME_BITS-1 -: ADDR_BITS];
  wire [DATA_BITS-1:0] f_data = shift[DATA_BITS-1:0];
  wire                 commit = cs_rise && (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync <= '1;
      ck_sync <= '0;
      sd_sync <= '0;
      cs_q    <= 1'b1;
      ck_q    <= 1'b0;
    end else begin
      cs_sync <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      ck_sync <= {ck_sync[SYNC_STAGES-2:0], sclk};
      sd_sync <= {sd_sync[SYNC_STAGES-2:0], sdata};
      cs_q    <= cs_s;
      ck_q    <= ck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift <= '0;
      cnt   <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
    end else if (ck_rise && !cs_s) begin
      shift <= {shift[FRAME_BITS-2:0], sd_s};
      if (cnt != FULL) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_lo <= '0;
      dac_hi <= '0;
      gain_r <= '0;
      ctl_r  <= '0;
    end else if (commit) begin
      case (f_addr)
        ADDR_BITS'(0): dac_lo <= f_data[7:0];
        ADDR_BITS'(1): dac_hi <= f_data[1:0];
        ADDR_BITS'(2): gain_r <= f_data[3:0];
        ADDR_BITS'(3): ctl_r  <= f_data[4:0];
        default: ;
      endcase
    end
  end

  assign clamp_code = {dac_hi, dac_lo};
  assign gain_code  = gain_r[2:0];
  assign gain_off   = gain_r[3];
  assign pwr_down   = ctl_r[0];
  assign clamp_dis  = ctl_r[1];
  assign twos_out   = ctl_r[2];
  assign clamp_sel  = ctl_r[3];
  assign out_en_n   = ctl_r[4];
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk #(
  parameter int FRAME_BITS = 12,
  parameter int CNT_W      = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_rise,
  input logic                  cs_fall,
  input logic [CNT_W-1:0]      cnt,
  input logic [FRAME_BITS-1:0] shift,
  input logic [9:0]            clamp_code,
  input logic [18:0]           cfg
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
  wire [3:0] addr = shift[FRAME_BITS-1 -: 4];

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(cfg));

  p_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt != FULL) |=> $stable(cfg));

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && addr >= 4'd4) |=> $stable(cfg));

  p_count_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (cnt == '0));

  p_count_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  p_dac_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt == FULL && addr == 4'd0) |=> (clamp_code[7:0] == $past(shift[7:0])));
endmodule

bind serial_cfg_port serial_cfg_port_chk #(
  .FRAME_BITS(FRAME_BITS),
  .CNT_W(CNT_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .cs_rise(cs_rise),
  .cs_fall(cs_fall),
  .cnt(cnt),
  .shift(shift),
  .clamp_code(clamp_code),
  .cfg({clamp_code, gain_code, gain_off, out_en_n, clamp_sel, twos_out, clamp_dis, pwr_down})
);

// File: tb/serial_cfg_port_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic [9:0] clamp_code;
  logic [2:0] gain_code;
  logic gain_off, out_en_n, clamp_sel, twos_out, clamp_dis, pwr_down;

  int total = 0, bad = 0;
  bit done = 0;

  logic [9:0] e_dac = '0;
  logic [2:0] e_gain = '0;
  logic e_goff = 0, e_oen = 0, e_sel = 0, e_twos = 0, e_dis = 0, e_pd = 0;

  always #2 clk = ~clk;

  serial_cfg_port #(.SYNC_STAGES(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .clamp_code(clamp_code), .gain_code(gain_code), .gain_off(gain_off),
    .out_en_n(out_en_n), .clamp_sel(clamp_sel), .twos_out(twos_out),
    .clamp_dis(clamp_dis), .pwr_down(pwr_down)
  );

  function automatic logic [18:0] act_vec();
    return {clamp_code, gain_code, gain_off, out_en_n, clamp_sel, twos_out, clamp_dis, pwr_down};
  endfunction
  function automatic logic [18:0] exp_vec();
    return {e_dac, e_gain, e_goff, e_oen, e_sel, e_twos, e_dis, e_pd};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, int'(act_vec()), int'(exp_vec()));
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i];
      repeat (3) @(posedge clk);
      sclk = 1'b1;
      repeat (4) @(posedge clk);
      sclk = 1'b0;
      repeat (3) @(posedge clk);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int n);
    cs_n = 1'b0;
    repeat (5) @(posedge clk);
    send_bits(w, n);
    repeat (5) @(posedge clk);
    cs_n = 1'b1;
    repeat (12) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    frame({4'h0, a, d}, 12);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_all("R1 reset state");
  endtask

  task automatic t_dac();
    wr(4'd0, 8'hA5); e_dac[7:0] = 8'hA5;
    chk("R2 dac low byte", int'(clamp_code), int'(e_dac));
    wr(4'd1, 8'hFE); e_dac[9:8] = 2'b10;
    chk("R3 dac high bits", int'(clamp_code), int'(e_dac));
    chk_all("R11 addr1 upper bits ignored");
  endtask

  task automatic t_gain();
    wr(4'd2, 8'hFD); e_gain = 3'd5; e_goff = 1'b1;
    chk("R4 gain code", int'(gain_code), 5);
    chk_all("R11 addr2 upper bits ignored");
    wr(4'd2, 8'h02); e_gain = 3'd2; e_goff = 1'b0;
    chk_all("R4 gain rewrite");
  endtask

  task automatic t_ctl();
    wr(4'd3, 8'hF5);
    e_pd = 1; e_dis = 0; e_twos = 1; e_sel = 0; e_oen = 1;
    chk_all("R5 control flags pattern A / R11 bits 7:5");
    wr(4'd3, 8'h0A);
    e_pd = 0; e_dis = 1; e_twos = 0; e_sel = 1; e_oen = 0;
    chk_all("R5 control flags pattern B");
  endtask

  task automatic t_commit_edge();
    cs_n = 1'b0;
    repeat (5) @(posedge clk);
    send_bits({4'h0, 4'd0, 8'h3C}, 12);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk_all("R6 no change while select low");
    cs_n = 1'b1;
    repeat (12) @(posedge clk);
    @(negedge clk);
    e_dac[7:0] = 8'h3C;
    chk_all("R6 commit on select rise");
  endtask

  task automatic t_short();
    frame({4'h0, 4'd0, 8'h11} >> 1, 11);
    chk_all("R7 11-bit frame discarded");
  endtask

  task automatic t_long();
    frame(16'hF207, 16);
    e_gain = 3'd7; e_goff = 1'b0;
    chk_all("R8 16-bit frame uses last 12");
  endtask

  task automatic t_reserved();
    wr(4'd4, 8'hFF);
    chk_all("R9 write to addr 4");
    wr(4'd15, 8'hFF);
    chk_all("R9 write to addr 15");
  endtask

  task automatic t_idle_clock();
    send_bits({4'h0, 4'd0, 8'h99}, 12);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk_all("R10 clocks with select high");
    frame({12'h0, 4'hF}, 4);
    chk_all("R10 count restarts on select fall");
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_dac();
    t_gain();
    t_ctl();
    t_commit_edge();
    t_short();
    t_long();
    t_reserved();
    t_idle_clock();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule